// File: doc/BRIEF.md
# Indexed Channel Multiplexer

This block passes one token from one of several valid/ready data channels to a single valid/ready output. The input to forward is named by a token on a separate select channel, which has its own handshake and carries an index. A transfer happens only when the select token and the indexed data token are both present and the output accepts. In that cycle both tokens are consumed together. Inputs that were not named are never acknowledged.

The block has no storage and no clock, so every output is a function of the inputs in the same cycle. It is meant to sit between pipeline stages that supply their own registers. The select index is cut down to the number of bits needed to address the data inputs. From that index the block forms a one-hot vector, which picks the data and steers the acknowledge.

Top module: `sel_chan_mux`

## Requirements
- R1: Only the low ceil(log2(N_IN)) bits of `sel_idx` are used. Its upper bits have no effect on any output (with defaults N_IN=4, SEL_W=3, bit 2 is ignored).
- R2: `out_valid` is high exactly when `sel_valid` is high and the data input named by the truncated index has its valid high.
- R3: While `out_valid` is high, `out_data` equals `in_data` of the indexed input. `in_data` is packed with input i in bits [i*DATA_W +: DATA_W].
- R4: `sel_ready` is high exactly when `out_valid` and `out_ready` are both high.
- R5: `in_ready[i]` is high exactly when i equals the truncated index and `out_valid` and `out_ready` are both high. Every other input sees ready low.
- R6: When N_IN is not a power of two and the truncated index is N_IN or more, `out_valid`, `sel_ready` and every `in_ready` stay low.
- R7: Each output transfer consumes exactly one select token and exactly one data token. Over any run, the counts of select handshakes, data-input handshakes and output handshakes are equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sel_valid | input | 1 | Select token present |
| sel_ready | output | 1 | Select token consumed |
| sel_idx | input | SEL_W | Index of the input to forward |
| in_valid | input | N_IN | Per-input token present |
| in_ready | output | N_IN | Per-input token consumed |
| in_data | input | N_IN*DATA_W | Packed input payloads, input i at [i*DATA_W +: DATA_W] |
| out_valid | output | 1 | Output token present |
| out_ready | input | 1 | Downstream accepts |
| out_data | output | DATA_W | Forwarded payload |

## Verification
The block has no registers, so every result is due in the same cycle as the stimulus that causes it, with zero cycles of latency. The driver applies each input pattern on the falling clock edge and pushes the expected output into a queue. The monitor samples and compares on the following rising edge, after the combinational paths have settled and before the next pattern is applied. A second instance with three inputs covers the out-of-range index. Running handshake counts taken from the ports check that no token is lost or duplicated.

// File: rtl/chanmux_pkg.sv
package chanmux_pkg;
  // bits needed to address n inputs, at least one
  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/chanmux_decode.sv
module chanmux_decode
  import chanmux_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int SEL_W = 3
) (
  input  logic [SEL_W-1:0] sel_idx,
  output logic [N_IN-1:0]  onehot
);
  localparam int IDX_W = idx_bits(N_IN);

  logic [IDX_W-1:0] idx_t;

  generate
    if (SEL_W > IDX_W) begin : g_trunc
      logic unused_hi_bits;
      assign unused_hi_bits = ^sel_idx[SEL_W-1:IDX_W];
      assign idx_t = sel_idx[IDX_W-1:0];
    end else if (SEL_W == IDX_W) begin : g_same
      assign idx_t = sel_idx;
    end else begin : g_widen
      assign idx_t = {{(IDX_W-SEL_W){1'b0}}, sel_idx};
    end
  endgenerate

  // shifting past N_IN-1 leaves the vector all zero
  always_comb begin
    onehot = N_IN'(1) << idx_t;
  end

  // R1
  always_comb begin
    onehot_shape_chk: assert ($onehot0(onehot))
      else $error("one-hot select has more than one bit set");
  end
endmodule

// File: rtl/chanmux_pick.sv
module chanmux_pick #(
  parameter int N_IN   = 4,
  parameter int DATA_W = 8
) (
  input  logic [N_IN-1:0]             onehot,
  input  logic [N_IN-1:0]             in_valid,
  input  logic [N_IN-1:0][DATA_W-1:0] in_data,
  output logic                        pick_valid,
  output logic [DATA_W-1:0]           pick_data
);
  always_comb begin
    pick_valid = |(onehot & in_valid);
    pick_data  = '0;
    for (int i = 0; i < N_IN; i++) begin
      pick_data = pick_data | (in_data[i] & {DATA_W{onehot[i]}});
    end
  end
endmodule

// File: rtl/chanmux_ackgen.sv
module chanmux_ackgen #(
  parameter int N_IN = 4
) (
  input  logic [N_IN-1:0] onehot,
  input  logic            sel_valid,
  input  logic            pick_valid,
  input  logic            out_ready,
  output logic            out_valid,
  output logic            sel_ready,
  output logic [N_IN-1:0] in_ready
);
  logic fire;

  always_comb begin
    out_valid = pick_valid & sel_valid;
    fire      = out_valid & out_ready;
    sel_ready = fire;
    in_ready  = onehot & {N_IN{fire}};
  end

  // R2
  always_comb begin
    out_needs_sel_chk: assert (!out_valid || sel_valid)
      else $error("output valid without select token");
  end

  // R4
  always_comb begin
    sel_ack_gated_chk: assert (!sel_ready || out_ready)
      else $error("select consumed while output stalled");
  end

  // R5
  always_comb begin
    single_in_ack_chk: assert ($onehot0(in_ready))
      else $error("more than one input acknowledged");
  end

  // R7
  always_comb begin
    paired_ack_chk: assert ((|in_ready) == sel_ready)
      else $error("select and data acknowledges not paired");
  end
endmodule

// File: rtl/sel_chan_mux.sv
module sel_chan_mux #(
  parameter int N_IN   = 4,
  parameter int DATA_W = 8,
  parameter int SEL_W  = 3
) (
  input  logic                     sel_valid,
  output logic                     sel_ready,
  input  logic [SEL_W-1:0]         sel_idx,
  input  logic [N_IN-1:0]          in_valid,
  output logic [N_IN-1:0]          in_ready,
  input  logic [N_IN*DATA_W-1:0]   in_data,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [DATA_W-1:0]        out_data
);
  logic [N_IN-1:0]             onehot;
  logic                        pick_valid;
  logic [N_IN-1:0][DATA_W-1:0] data_arr;

  always_comb begin
    for (int i = 0; i < N_IN; i++) begin
      data_arr[i] = in_data[i*DATA_W +: DATA_W];
    end
  end

  chanmux_decode #(.N_IN(N_IN), .SEL_W(SEL_W)) u_decode (
    .sel_idx (sel_idx),
    .onehot  (onehot)
  );

  chanmux_pick #(.N_IN(N_IN), .DATA_W(DATA_W)) u_pick (
    .onehot     (onehot),
    .in_valid   (in_valid),
    .in_data    (data_arr),
    .pick_valid (pick_valid),
    .pick_data  (out_data)
  );

  chanmux_ackgen #(.N_IN(N_IN)) u_ack (
    .onehot     (onehot),
    .sel_valid  (sel_valid),
    .pick_valid (pick_valid),
    .out_ready  (out_ready),
    .out_valid  (out_valid),
    .sel_ready  (sel_ready),
    .in_ready   (in_ready)
  );

  // R3
  always_comb begin
    for (int i = 0; i < N_IN; i++) begin
      acked_data_match_chk: assert (!in_ready[i] || (out_data == data_arr[i]))
        else $error("forwarded data differs from acknowledged input");
    end
  end

  // R5
  always_comb begin
    for (int i = 0; i < N_IN; i++) begin
      ack_needs_valid_chk: assert (!in_ready[i] || in_valid[i])
        else $error("input acknowledged without a token");
    end
  end
endmodule

// File: tb/sel_chan_mux_tb.sv
module sel_chan_mux_tb;
  localparam int N  = 4;
  localparam int DW = 8;
  localparam int SW = 3;

  typedef struct packed {
    logic          ov;
    logic [DW-1:0] od;
    logic          sr;
    logic [N-1:0]  ir;
    logic          ov3;
    logic          sr3;
    logic [2:0]    ir3;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  always #4 clk = ~clk;

  logic          sel_valid, sel_ready, out_valid, out_ready;
  logic [SW-1:0] sel_idx;
  logic [N-1:0]  in_valid, in_ready;
  logic [N*DW-1:0] in_data;
  logic [DW-1:0] out_data;

  logic          sel_valid3, sel_ready3, out_valid3;
  logic [1:0]    sel_idx3;
  logic [2:0]    in_valid3, in_ready3;
  logic [3*DW-1:0] in_data3;
  logic [DW-1:0] out_data3;

  sel_chan_mux #(.N_IN(N), .DATA_W(DW), .SEL_W(SW)) u_dut (
    .sel_valid(sel_valid), .sel_ready(sel_ready), .sel_idx(sel_idx),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  sel_chan_mux #(.N_IN(3), .DATA_W(DW), .SEL_W(2)) u_dut_odd (
    .sel_valid(sel_valid3), .sel_ready(sel_ready3), .sel_idx(sel_idx3),
    .in_valid(in_valid3), .in_ready(in_ready3), .in_data(in_data3),
    .out_valid(out_valid3), .out_ready(out_ready), .out_data(out_data3)
  );

  int checks = 0, errors = 0;
  int n_sel = 0, n_in = 0, n_out = 0;
  exp_t q[$];
  bit done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // driver: apply one pattern on the falling edge, push its expected result
  task automatic drive(input logic sv, input logic [SW-1:0] si,
                       input logic [N-1:0] iv, input logic [N*DW-1:0] id,
                       input logic orr, input logic sv3, input logic [1:0] si3,
                       input logic [2:0] iv3);
    exp_t e;
    int k;
    @(negedge clk);
    sel_valid = sv; sel_idx = si; in_valid = iv; in_data = id; out_ready = orr;
    sel_valid3 = sv3; sel_idx3 = si3; in_valid3 = iv3;
    in_data3 = id[3*DW-1:0];
    k = int'(si[1:0]);
    e.ov = sv & iv[k];
    e.od = id[k*DW +: DW];
    e.sr = e.ov & orr;
    e.ir = e.sr ? (N'(1) << k) : '0;
    e.ov3 = (si3 != 2'd3) ? (sv3 & iv3[si3]) : 1'b0;
    e.sr3 = e.ov3 & orr;
    e.ir3 = e.sr3 ? (3'(1) << si3) : '0;
    q.push_back(e);
  endtask

  // monitor: results are combinational, so they are due at the next rising edge
  always @(posedge clk) begin
    if (rst_n && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(out_valid === e.ov, "R2", "out_valid", 32'(out_valid), 32'(e.ov));
      if (e.ov)
        check(out_data === e.od, "R3", "out_data", 32'(out_data), 32'(e.od));
      check(sel_ready === e.sr, "R4", "sel_ready", 32'(sel_ready), 32'(e.sr));
      check(in_ready === e.ir, "R5", "in_ready", 32'(in_ready), 32'(e.ir));
      check({out_valid3, sel_ready3, in_ready3} === {e.ov3, e.sr3, e.ir3},
            "R6", "odd-width instance", 32'({out_valid3, sel_ready3, in_ready3}),
            32'({e.ov3, e.sr3, e.ir3}));
      n_sel += int'(sel_valid & sel_ready);
      n_in  += $countones(in_valid & in_ready);
      n_out += int'(out_valid & out_ready);
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N*DW-1:0] pat;
    rst_n = 1'b0;
    sel_valid = 0; sel_idx = '0; in_valid = '0; in_data = '0; out_ready = 0;
    sel_valid3 = 0; sel_idx3 = '0; in_valid3 = '0; in_data3 = '0;
    #2;
    // idle state: nothing valid, nothing acknowledged
    check(out_valid === 1'b0 && sel_ready === 1'b0 && in_ready === '0,
          "R2", "idle outputs", 32'({out_valid, sel_ready, in_ready}), 32'h0);
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    pat = 32'hD4C3B2A1;
    // directed: each index, output accepting
    for (int k = 0; k < N; k++)
      drive(1, SW'(k), 4'hF, pat, 1, 1, 2'(k % 3), 3'h7);
    // R1: upper select bit set must not change anything
    for (int k = 0; k < N; k++)
      drive(1, SW'(k + 4), 4'hF, pat, 1, 1, 2'(k % 3), 3'h7);
    // stalled output: valid but no acknowledges (R4, R5)
    drive(1, 3'd2, 4'hF, pat, 0, 1, 2'd1, 3'h7);
    // indexed input empty, others full
    drive(1, 3'd1, 4'b1101, pat, 1, 1, 2'd0, 3'b110);
    // select absent
    drive(0, 3'd3, 4'hF, pat, 1, 0, 2'd2, 3'h7);
    // R6: index 3 on the three-input instance
    drive(1, 3'd3, 4'hF, pat, 1, 1, 2'd3, 3'h7);
    drive(1, 3'd0, 4'hF, pat, 1, 1, 2'd3, 3'h7);
    // random traffic (R7 conservation counted in monitor)
    for (int t = 0; t < 3000; t++)
      drive(1'($urandom), 3'($urandom), 4'($urandom), 32'($urandom),
            1'($urandom), 1'($urandom), 2'($urandom), 3'($urandom));
    @(posedge clk);
    @(negedge clk);
    check(n_sel == n_in, "R7", "select vs input handshakes", 32'(n_sel), 32'(n_in));
    check(n_out == n_sel, "R7", "output vs select handshakes", 32'(n_out), 32'(n_sel));
    check(q.size() == 0, "R7", "pending expectations", 32'(q.size()), 32'h0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule